// File: doc/BRIEF.md
# Five-State JK Sequence Counter

This block is a 3-bit synchronous counter whose state lives in three JK flip-flop stages on one shared clock. It does not count in binary. It runs a fixed five-state loop: 001, 011, 010, 111, 110, and then back to 001. Every step comes from hand-minimised J and K equations and not from an adder. Code 101 is not in the loop, but it drops into the loop at 001 on its next step.

Codes 000 and 100 were left as don't-cares when the equations were minimised. The equations therefore carry both codes to 000, and 000 then stays at 000. The block raises a flag whenever the state holds either of these two codes, so that surrounding logic can notice the lock-up.

A synchronous active-low reset loads the start code. An enable input freezes the counter by forcing every J and K input to zero. The reset code is a parameter whose default is 001.

Top module: `jkseq_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state loads `RESET_CODE` (default 001) on that edge, whatever the value of `en`.
- R2: With `en` high, the state steps on each rising edge through 001→011→010→111→110→001. `state[2]` is the most significant stage and `state[0]` is the least.
- R3: With `en` high, state 101 goes to 001 on the next rising edge.
- R4: With `en` high, state 100 goes to 000, and state 000 stays at 000 on every later edge.
- R5: With `en` low and `rst_n` high, the state does not change on a rising edge.
- R6: `illegal` is high in the same cycle that the state is 000 or 100, and low for every other code.
- R7: Each stage obeys JK rules on a rising edge: J=0 K=0 holds, J=0 K=1 clears, J=1 K=0 sets, and J=1 K=1 inverts.
- R8: Starting from 001 with `en` held high, the state is back at 001 after exactly five edges and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads the reset code |
| en | input | 1 | Count enable; when low, all J/K inputs are forced to 0 |
| state | output | 3 | Present counter code, bit 2 most significant |
| illegal | output | 1 | High while the state is 000 or 100 |

## Verification
Each change of state is due on the first rising edge after the enable or reset level that causes it, with no further register in the path. `illegal` follows the state combinationally in that same cycle. The bench drives every input on the falling edge and reads `state` and `illegal` on the next falling edge, which is half a period after the edge that updates them. The unused codes cannot be reached from 001, so three more copies of the counter are reset into 101, 100 and 000 and stepped in lockstep with the main copy. All four copies are compared each cycle against a transition table indexed by the present code.

// File: rtl/jkseq_pkg.sv
// Package: shared widths and code values for the five-state JK counter.
// Assumes: state bit 2 is the most significant stage.
package jkseq_pkg;
    localparam int STAGES = 3;
    typedef logic [STAGES-1:0] code_t;

    localparam code_t CODE_START  = 3'b001;
    localparam code_t CODE_ENTRY  = 3'b101;
    localparam code_t CODE_DEAD_A = 3'b000;
    localparam code_t CODE_DEAD_B = 3'b100;
endpackage

// File: rtl/jkseq_stage.sv
// Module: one JK flip-flop stage with a synchronous active-low reset.
// Does: holds, clears, sets or inverts q on the rising clock edge, as chosen by j and k.
// Assumes: j and k are settled before the edge; RST_VAL is the bit loaded in reset.
module jkseq_stage #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic j,
    input  logic k,
    output logic q
);

    // Stage register: reset first, then the JK action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            unique case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!j && !k) |=> $stable(q));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!j && k) |=> !q);
    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (j && !k) |=> q);
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (j && k) |=> (q != $past(q)));

endmodule

// File: rtl/jkseq_excite.sv
// Module: J/K input logic for the three counter stages.
// Does: forms each stage's J and K from the present code; a low enable forces all of them to 0.
// Assumes: code bit 2 is the most significant stage; 000 and 100 were don't-cares in minimisation.
module jkseq_excite
    import jkseq_pkg::*;
(
    input  code_t             q,
    input  logic              en,
    output logic [STAGES-1:0] j,
    output logic [STAGES-1:0] k
);

    logic [STAGES-1:0] j_raw;
    logic [STAGES-1:0] k_raw;

    // Minimised excitation equations, one pair per stage.
    always_comb begin
        j_raw[2] = ~q[2] &  q[1] & ~q[0];
        k_raw[2] =  q[2] & (~q[1] | ~q[0]);
        j_raw[1] = ~q[2] & ~q[1] &  q[0];
        k_raw[1] =  q[2] &  q[1] & ~q[0];
        j_raw[0] =  q[1] & ~q[0];
        k_raw[0] =  q[1] &  q[0];
    end

    // Enable gating: with en low every stage sees J=K=0 and holds.
    always_comb begin
        j = en ? j_raw : '0;
        k = en ? k_raw : '0;
    end

endmodule

// File: rtl/jkseq_counter.sv
// Module: top of the five-state JK sequence counter.
// Does: three JK stages plus excitation logic step 001,011,010,111,110; 101 enters at 001;
//       000 and 100 fall into a lock-up at 000 and raise the illegal flag.
// Assumes: rst_n is synchronous and active low and overrides en.
module jkseq_counter
    import jkseq_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'b001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [2:0] state,
    output logic       illegal
);

    code_t             q_w;
    logic [STAGES-1:0] j_w;
    logic [STAGES-1:0] k_w;

    jkseq_excite u_excite (
        .q  (q_w),
        .en (en),
        .j  (j_w),
        .k  (k_w)
    );

    // One JK stage per state bit, each reset to its own bit of RESET_CODE.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        jkseq_stage #(
            .RST_VAL (RESET_CODE[i])
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .j     (j_w[i]),
            .k     (k_w[i]),
            .q     (q_w[i])
        );
    end

    // Output drive and detection of the two unused codes.
    always_comb begin
        state   = q_w;
        illegal = (q_w == CODE_DEAD_A) || (q_w == CODE_DEAD_B);
    end

    assert_loop_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == 3'b110) |=> (state == CODE_START));
    assert_loop_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == CODE_START) |=> (state == 3'b011));
    assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == CODE_ENTRY) |=> (state == CODE_START));
    assert_lockup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && illegal) |=> (state == CODE_DEAD_A && illegal));
    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state));
    assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == CODE_DEAD_B) |=> illegal);

endmodule

// File: tb/jkseq_counter_tb.sv
module jkseq_counter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;

    logic [2:0] st_main, st_entry, st_deadb, st_deada;
    logic       il_main, il_entry, il_deadb, il_deada;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference: next code for each present code when enabled (index = present code).
    localparam logic [2:0] NEXT_TBL [0:7] = '{
        3'd0, 3'd3, 3'd7, 3'd2, 3'd0, 3'd1, 3'd1, 3'd6
    };

    always #10 clk = ~clk;  // 50 MHz

    jkseq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .state(st_main), .illegal(il_main));
    jkseq_counter #(.RESET_CODE(3'b101)) u_dut_entry (
        .clk(clk), .rst_n(rst_n), .en(en), .state(st_entry), .illegal(il_entry));
    jkseq_counter #(.RESET_CODE(3'b100)) u_dut_deadb (
        .clk(clk), .rst_n(rst_n), .en(en), .state(st_deadb), .illegal(il_deadb));
    jkseq_counter #(.RESET_CODE(3'b000)) u_dut_deada (
        .clk(clk), .rst_n(rst_n), .en(en), .state(st_deada), .illegal(il_deada));

    function automatic logic flag_of(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b100);
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One rising edge, then wait to the falling edge to sample.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [2:0] e_main, e_entry, e_deadb, e_deada;

        // R1: reset loads each copy's reset code.
        step();
        step();
        chk("R1 main reset", st_main, 3'b001);
        chk("R1 entry reset", st_entry, 3'b101);
        chk("R1 deadb reset", st_deadb, 3'b100);
        chk("R1 deada reset", st_deada, 3'b000);
        chk("R6 flag main", {2'b0, il_main}, 3'b000);
        chk("R6 flag deadb", {2'b0, il_deadb}, 3'b001);
        chk("R6 flag deada", {2'b0, il_deada}, 3'b001);

        rst_n = 1'b1;
        e_main = 3'b001; e_entry = 3'b101; e_deadb = 3'b100; e_deada = 3'b000;

        // Table walk, R2/R3/R4/R6/R8.
        for (int i = 1; i <= 12; i++) begin
            step();
            e_main  = NEXT_TBL[e_main];
            e_entry = NEXT_TBL[e_entry];
            e_deadb = NEXT_TBL[e_deadb];
            e_deada = NEXT_TBL[e_deada];
            chk("R2 loop", st_main, e_main);
            chk("R3 entry", st_entry, e_entry);
            chk("R4 lockup from 100", st_deadb, e_deadb);
            chk("R4 lockup at 000", st_deada, e_deada);
            chk("R6 flag", {2'b0, il_main}, {2'b0, flag_of(e_main)});
            chk("R6 flag lockup", {2'b0, il_deadb}, {2'b0, flag_of(e_deadb)});
            if (i % 5 == 0) chk("R8 period five", st_main, 3'b001);
            else            chk("R8 no early return", {2'b0, st_main == 3'b001}, 3'b000);
        end
        // After 12 steps main is at 010.

        // R5: freeze with enable low.
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5 hold", st_main, 3'b010);
            chk("R5 hold entry copy", st_entry, e_entry);
        end
        en = 1'b1;
        step();
        chk("R5 resume", st_main, 3'b111);
        step();
        chk("R7 stage clear on 111->110", st_main, 3'b110);
        step();
        chk("R7 clear/clear/set on 110->001", st_main, 3'b001);
        step();
        chk("R2 001->011", st_main, 3'b011);

        // R1: reset overrides enable mid-loop, and during enable low.
        rst_n = 1'b0;
        step();
        chk("R1 reset priority", st_main, 3'b001);
        chk("R1 reset entry copy", st_entry, 3'b101);
        en = 1'b0;
        step();
        chk("R1 reset with en low", st_deada, 3'b000);
        chk("R1 reset with en low main", st_main, 3'b001);
        rst_n = 1'b1;
        en = 1'b1;
        step();
        chk("R3 entry after reset", st_entry, 3'b001);
        chk("R4 100->000 after reset", st_deadb, 3'b000);
        chk("R6 flag on 000", {2'b0, il_deadb}, 3'b001);
        chk("R6 flag clear on 001", {2'b0, il_entry}, 3'b000);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule